// File: doc/BRIEF.md
# Indexed Effective-Address Generator with Base Writeback

This block computes the memory address for a load/store path from a base register value and an offset. The offset is either a zero-extended immediate or a second register value passed through a shift stage. The shift stage can apply a left logical shift, a right logical shift, a right arithmetic shift, a right rotate, or a one-bit extended rotate through a carry input. The offset is then added to or subtracted from the base.

Three addressing forms are supported. In offset-only form the sum is issued as the address and the base register is left alone. In pre-index form the sum is issued and also returned as the new base value. In post-index form the untouched base is issued and the sum is returned as the new base value. A strobe accepts one request per cycle. The address, the new base value and a writeback enable appear on the following clock edge together with an output valid.

Top module: `idxaddr_unit`

## Requirements
- R1: With `use_reg_i`=0 the offset is `imm_i` zero-extended to 32 bits. With `use_reg_i`=1 the offset is the shifted `offreg_i`.
- R2: `shift_kind_i` encodings: 0 shifts left logically, 1 shifts right logically, 2 shifts right arithmetically, 3 rotates right, each by `shift_amt_i` (0..31). An amount of 0 passes `offreg_i` unchanged. The reserved codes 5, 6 and 7 also pass it unchanged.
- R3: `shift_kind_i`=4 is the extended rotate: the result is {`carry_i`, `offreg_i`[31:1]}, and `shift_amt_i` is ignored.
- R4: `sub_i`=0 adds the offset to the base and `sub_i`=1 subtracts it, modulo 2^32.
- R5: `mode_i`=0 (offset-only): `addr_o` = base ± offset and `wb_en_o`=0.
- R6: `mode_i`=1 (pre-index): `addr_o` = `wb_data_o` = base ± offset and `wb_en_o`=1.
- R7: `mode_i`=2 (post-index): `addr_o` = base, `wb_data_o` = base ± offset and `wb_en_o`=1.
- R8: `mode_i`=3 is reserved and behaves exactly as offset-only.
- R9: Results appear on the first rising edge after `in_valid_i` is sampled high. `out_valid_o` is high for exactly that cycle for each accepted request, and `wb_en_o` is never high while `out_valid_o` is low.
- R10: While `in_valid_i` is low, `addr_o` and `wb_data_o` keep their last values, whatever the other inputs do.
- R11: After reset, `out_valid_o`, `wb_en_o`, `addr_o` and `wb_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid_i | input | 1 | Request strobe |
| base_i | input | 32 | Base register value |
| offreg_i | input | 32 | Offset register value |
| imm_i | input | 12 | Immediate offset |
| use_reg_i | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| shift_kind_i | input | 3 | Shift operation code |
| shift_amt_i | input | 5 | Shift amount |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| mode_i | input | 2 | Addressing form |
| carry_i | input | 1 | Carry input for the extended rotate |
| out_valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Memory address to issue |
| wb_data_o | output | 32 | New base register value |
| wb_en_o | output | 1 | Base register writeback enable |

## Verification
The hardest cases to reach from the ports are those where a result must not depend on an input. Two examples are the extended rotate, which must ignore a nonzero shift amount, and the hold behaviour, where every data input changes while the strobe is low. The bench drives the extended rotate with a large shift amount and both carry values, using operands whose low and high bits differ, so that any use of the amount or a wrong carry shows up in the address. It then changes base, offset and mode with no strobe and confirms that the previous address and writeback value remain on the outputs. Subtraction is checked where the result wraps below zero, and the arithmetic shift is checked with a negative register value.

// File: rtl/idxaddr_pkg.sv
package idxaddr_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_e;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;
endpackage

// File: rtl/idxaddr_shifter.sv
module idxaddr_shifter
  import idxaddr_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    val_i,
  input  logic [2:0]      kind_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic            carry_i,
  output logic [W-1:0]    val_o
);
  logic [2*W-1:0] rot_dbl;

  always_comb begin
    rot_dbl = {val_i, val_i} >> amt_i;
    case (kind_i)
      SH_LSL:  val_o = val_i << amt_i;
      SH_LSR:  val_o = val_i >> amt_i;
      SH_ASR:  val_o = W'($signed(val_i) >>> amt_i);
      SH_ROR:  val_o = rot_dbl[W-1:0];
      SH_RRX:  val_o = {carry_i, val_i[W-1:1]};
      default: val_o = val_i;
    endcase
  end
endmodule

// File: rtl/idxaddr_calc.sv
module idxaddr_calc #(
  parameter int W     = 32,
  parameter int IMM_W = 12
) (
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     shifted_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_reg_i,
  input  logic             sub_i,
  output logic [W-1:0]     sum_o
);
  localparam int PAD_W = W - IMM_W;
  logic [W-1:0] offset;

  always_comb begin
    offset = use_reg_i ? shifted_i : {{PAD_W{1'b0}}, imm_i};
    sum_o  = sub_i ? (base_i - offset) : (base_i + offset);
  end
endmodule

// File: rtl/idxaddr_unit.sv
module idxaddr_unit
  import idxaddr_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     offreg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_reg_i,
  input  logic [2:0]       shift_kind_i,
  input  logic [SH_W-1:0]  shift_amt_i,
  input  logic             sub_i,
  input  logic [1:0]       mode_i,
  input  logic             carry_i,
  output logic             out_valid_o,
  output logic [W-1:0]     addr_o,
  output logic [W-1:0]     wb_data_o,
  output logic             wb_en_o
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [W-1:0] shifted, sum;

  idxaddr_shifter #(.W(W), .SH_W(SH_W)) u_shift (
    .val_i   (offreg_i),
    .kind_i  (shift_kind_i),
    .amt_i   (shift_amt_i),
    .carry_i (carry_i),
    .val_o   (shifted)
  );

  idxaddr_calc #(.W(W), .IMM_W(IMM_W)) u_calc (
    .base_i    (base_i),
    .shifted_i (shifted),
    .imm_i     (imm_i),
    .use_reg_i (use_reg_i),
    .sub_i     (sub_i),
    .sum_o     (sum)
  );

  // next-state
  logic [W-1:0] addr_d, wb_d;
  logic         wben_d;
  always_comb begin
    wb_d = sum;
    case (mode_i)
      AM_PRE:  begin addr_d = sum;    wben_d = 1'b1; end
      AM_POST: begin addr_d = base_i; wben_d = 1'b1; end
      default: begin addr_d = sum;    wben_d = 1'b0; end
    endcase
  end

  // registers
  logic [W-1:0] addr_q, wb_q;
  logic         wben_q, valid_q;
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      addr_q  <= '0;
      wb_q    <= '0;
      wben_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        addr_q <= addr_d;
        wb_q   <= wb_d;
        wben_q <= wben_d;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign addr_o      = addr_q;
  assign wb_data_o   = wb_q;
  assign wb_en_o     = valid_q & wben_q;

  // assertions
  assert_zero_amt_pass_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    (shift_amt_i == '0 && shift_kind_i <= 3'd3) |-> (shifted == offreg_i));
  assert_rrx_carry_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    (shift_kind_i == 3'd4) |-> (shifted[W-1] == carry_i && shifted[W-2:0] == offreg_i[W-1:1]));
  assert_no_wb_offset_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> (out_valid_o && !wb_en_o));
  assert_pre_same_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid_i && mode_i == 2'd1) |=> (wb_en_o && addr_o == wb_data_o));
  assert_post_base_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid_i && mode_i == 2'd2) |=> (wb_en_o && addr_o == $past(base_i)));
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    !in_valid_i |=> (!out_valid_o && !wb_en_o));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    !in_valid_i |=> ($stable(addr_o) && $stable(wb_data_o)));
endmodule

// File: tb/idxaddr_unit_tb.sv
module idxaddr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid_i;
  logic [31:0] base_i, offreg_i;
  logic [11:0] imm_i;
  logic        use_reg_i;
  logic [2:0]  shift_kind_i;
  logic [4:0]  shift_amt_i;
  logic        sub_i;
  logic [1:0]  mode_i;
  logic        carry_i;
  logic        out_valid_o;
  logic [31:0] addr_o, wb_data_o;
  logic        wb_en_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  idxaddr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .base_i(base_i),
    .offreg_i(offreg_i), .imm_i(imm_i), .use_reg_i(use_reg_i),
    .shift_kind_i(shift_kind_i), .shift_amt_i(shift_amt_i), .sub_i(sub_i),
    .mode_i(mode_i), .carry_i(carry_i), .out_valid_o(out_valid_o),
    .addr_o(addr_o), .wb_data_o(wb_data_o), .wb_en_o(wb_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference shift, written bit by bit from the requirement text
  function automatic logic [31:0] ref_shift(input logic [31:0] v, input logic [2:0] k,
                                            input logic [4:0] a, input logic c);
    logic [31:0] r = v;
    if (k == 3'd4) return {c, v[31:1]};
    if (k > 3'd4) return v;
    for (int i = 0; i < int'(a); i++) begin
      case (k)
        3'd0: r = {r[30:0], 1'b0};
        3'd1: r = {1'b0, r[31:1]};
        3'd2: r = {r[31], r[31:1]};
        default: r = {r[0], r[31:1]};
      endcase
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] b, input logic [31:0] o, input logic [11:0] im,
                       input logic ur, input logic [2:0] k, input logic [4:0] a,
                       input logic s, input logic [1:0] m, input logic c);
    @(negedge clk);
    base_i = b; offreg_i = o; imm_i = im; use_reg_i = ur; shift_kind_i = k;
    shift_amt_i = a; sub_i = s; mode_i = m; carry_i = c; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  // apply one request and check all outputs against the model
  task automatic expect_op(input string tag, input logic [31:0] b, input logic [31:0] o,
                           input logic [11:0] im, input logic ur, input logic [2:0] k,
                           input logic [4:0] a, input logic s, input logic [1:0] m,
                           input logic c);
    logic [31:0] off, sum, ea;
    logic        we;
    off = ur ? ref_shift(o, k, a, c) : {20'd0, im};
    sum = s ? b - off : b + off;
    ea  = (m == 2'd2) ? b : sum;
    we  = (m == 2'd1 || m == 2'd2);
    apply(b, o, im, ur, k, a, s, m, c);
    chk({tag, " addr"}, addr_o, ea);
    chk({tag, " wb_data"}, wb_data_o, sum);
    chk({tag, " wb_en"}, {31'd0, wb_en_o}, {31'd0, we});
    chk({tag, " valid R9"}, {31'd0, out_valid_o}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset addr", addr_o, 32'd0);
    chk("R11 reset wb_data", wb_data_o, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en_o}, 32'd0);
    chk("R11 reset valid", {31'd0, out_valid_o}, 32'd0);
  endtask

  task automatic t_imm();
    expect_op("R1 R5 imm add", 32'h0000_1000, 32'hDEAD_BEEF, 12'hFFF, 1'b0, 3'd0, 5'd4, 1'b0, 2'd0, 1'b0);
    expect_op("R1 reg ignored imm", 32'h0000_0100, 32'h0000_0010, 12'h7FF, 1'b1, 3'd0, 5'd0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_sub();
    expect_op("R4 sub wrap", 32'h0000_0010, 32'h0, 12'h020, 1'b0, 3'd0, 5'd0, 1'b1, 2'd0, 1'b0);
    expect_op("R4 sub reg", 32'h8000_0000, 32'h0000_0001, 12'h0, 1'b1, 3'd0, 5'd31, 1'b1, 2'd0, 1'b0);
  endtask

  task automatic t_shifts();
    expect_op("R2 lsl", 32'h0000_1000, 32'h0000_0123, 12'h0, 1'b1, 3'd0, 5'd3, 1'b0, 2'd0, 1'b0);
    expect_op("R2 lsr", 32'h0000_1000, 32'hF000_0F00, 12'h0, 1'b1, 3'd1, 5'd4, 1'b0, 2'd0, 1'b0);
    expect_op("R2 asr neg", 32'h0010_0000, 32'h8000_0100, 12'h0, 1'b1, 3'd2, 5'd8, 1'b0, 2'd0, 1'b0);
    expect_op("R2 ror", 32'h0, 32'h1234_56AB, 12'h0, 1'b1, 3'd3, 5'd8, 1'b0, 2'd0, 1'b0);
    expect_op("R2 ror amt0", 32'h0, 32'h8765_4321, 12'h0, 1'b1, 3'd3, 5'd0, 1'b0, 2'd0, 1'b0);
    expect_op("R2 asr amt0", 32'h0, 32'h8765_4321, 12'h0, 1'b1, 3'd2, 5'd0, 1'b0, 2'd0, 1'b0);
    expect_op("R2 reserved code6", 32'h10, 32'h0000_0F0F, 12'h0, 1'b1, 3'd6, 5'd9, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_rrx();
    expect_op("R3 rrx c1", 32'h0, 32'h0000_0003, 12'h0, 1'b1, 3'd4, 5'd17, 1'b0, 2'd0, 1'b1);
    expect_op("R3 rrx c0", 32'h0, 32'hF000_0002, 12'h0, 1'b1, 3'd4, 5'd31, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_modes();
    expect_op("R6 pre", 32'h2000_0000, 32'h4, 12'h0, 1'b1, 3'd0, 5'd2, 1'b0, 2'd1, 1'b0);
    expect_op("R7 post", 32'h2000_0000, 32'h4, 12'h0, 1'b1, 3'd0, 5'd2, 1'b1, 2'd2, 1'b0);
    expect_op("R8 reserved mode", 32'h3000_0000, 32'h0, 12'h0AB, 1'b0, 3'd0, 5'd0, 1'b0, 2'd3, 1'b0);
  endtask

  task automatic t_timing_hold();
    expect_op("R9 setup", 32'h5000_0000, 32'h0, 12'h010, 1'b0, 3'd0, 5'd0, 1'b0, 2'd1, 1'b0);
    @(negedge clk);
    base_i = 32'hFFFF_0000; imm_i = 12'h123; mode_i = 2'd0; sub_i = 1'b1;
    chk("R9 valid drops", {31'd0, out_valid_o}, 32'd0);
    chk("R9 wb_en drops", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
    chk("R10 hold addr", addr_o, 32'h5000_0010);
    chk("R10 hold wb_data", wb_data_o, 32'h5000_0010);
  endtask

  initial begin
    rst_n = 1'b0; in_valid_i = 1'b0; base_i = '0; offreg_i = '0; imm_i = '0;
    use_reg_i = 1'b0; shift_kind_i = '0; shift_amt_i = '0; sub_i = 1'b0;
    mode_i = '0; carry_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_imm();
    t_sub();
    t_shifts();
    t_rrx();
    t_modes();
    t_timing_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule